// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder with Inhibit

The block turns a 4-bit address into one active line out of sixteen. A register in front of the decoder holds the address. It takes a new address on each clock edge where the strobe is high and keeps its value while the strobe is low. The block therefore acts as a clocked, synthesizable form of a latch that is transparent while the strobe is high and freezes when the strobe falls.

An inhibit input drives every output to its inactive level and leaves the held address as it is. When inhibit drops, the output shows the held code again at once.

A compile-time parameter sets the output polarity. In active-high form the selected line is 1. In active-low form the selected line is 0. The active-low vector is always the bitwise complement of the active-high vector, and this includes the inhibited state.

Top module: `latched_line_decoder`

## Requirements
- R1: On each rising clock edge where `strobe` is 1, the held address takes the value of `addr_in`, and the outputs show that code from that edge on.
- R2: On a rising clock edge where `strobe` is 0, the held address does not change, whatever `addr_in` does.
- R3: `addr_in[3]` is the most significant bit of the address. Held code n selects output bit `sel_out[n]`, for n from 0 to 15.
- R4: With `ACTIVE_LOW` = 0 and `inhibit` = 0, the selected bit is 1 and all other bits are 0.
- R5: With `ACTIVE_LOW` = 1, `sel_out` is the bitwise complement of the active-high vector for the same inputs: the selected bit is 0 and all others are 1, or all bits are 1 while inhibited.
- R6: While `inhibit` is 1, every output bit is at its inactive level: all 0 for active-high, all 1 for active-low. This takes effect in the same cycle, with no clock edge needed.
- R7: `inhibit` does not change the held address. Loads (R1) and holds (R2) go on as usual while it is 1, so the held code appears on `sel_out` as soon as `inhibit` returns to 0.
- R8: A synchronous active-high `rst` clears the held address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the held address updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the held address |
| strobe | input | 1 | 1: load the address on each edge; 0: hold it |
| addr_in | input | 4 | Address to decode; bit 3 is the most significant |
| inhibit | input | 1 | 1: force all outputs to the inactive level |
| sel_out | output | 16 | Select lines, one-hot or one-cold depending on `ACTIVE_LOW` |

## Verification
The assertions check on every clock cycle four things:
- the held address follows `addr_in` under a high strobe and stays put under a low strobe;
- reset clears the held address;
- the raw decode always has exactly one bit set;
- `sel_out` is at the inactive level while inhibited, and otherwise has the single active bit of the chosen polarity.

Only the bench scenarios can show the following:
- the code-to-bit mapping across all sixteen addresses, in both polarities;
- which address is kept across a strobe fall while `addr_in` keeps changing;
- that a code loaded, or a code held, while inhibited comes back out intact when the inhibit is released.

// File: rtl/lld_pkg.sv
package lld_pkg;

    localparam int unsigned ADDR_W_DEF = 4;
    localparam int unsigned LINES_DEF  = 1 << ADDR_W_DEF;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } polarity_e;

    typedef struct packed {
        logic                  valid_sel;
        logic [ADDR_W_DEF-1:0] code;
    } held_addr_t;

    function automatic polarity_e polarity_of(input bit active_low);
        return active_low ? POL_LOW : POL_HIGH;
    endfunction

    function automatic logic [LINES_DEF-1:0] inactive_vector(input polarity_e pol);
        return (pol == POL_LOW) ? {LINES_DEF{1'b1}} : {LINES_DEF{1'b0}};
    endfunction

endpackage

// File: rtl/lld_addr_hold.sv
module lld_addr_hold #(
    parameter int unsigned ADDR_W = lld_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] code_q
);

    logic [ADDR_W-1:0] code_d;

    always_comb begin
        code_d = code_q;
        if (strobe) begin
            code_d = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    // R1
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (code_q == $past(addr_in)));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(code_q));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code_q == '0));

endmodule

// File: rtl/lld_onehot_dec.sv
module lld_onehot_dec #(
    parameter int unsigned ADDR_W = lld_pkg::ADDR_W_DEF,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] code,
    output logic [LINES-1:0]  onehot
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign onehot[i] = (code == ADDR_W'(i));
    end

    // R3
    single_line_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(onehot) == 1);

endmodule

// File: rtl/lld_out_drive.sv
module lld_out_drive #(
    parameter int unsigned LINES      = lld_pkg::LINES_DEF,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inhibit,
    input  logic [LINES-1:0] onehot,
    output logic [LINES-1:0] sel_out
);

    import lld_pkg::*;

    localparam polarity_e POL = polarity_of(ACTIVE_LOW);

    logic [LINES-1:0] gated;

    assign gated = inhibit ? '0 : onehot;

    if (POL == POL_LOW) begin : g_low
        assign sel_out = ~gated;

        // R6
        inhibit_idle_chk: assert property (@(posedge clk) disable iff (rst)
            inhibit |-> (sel_out == {LINES{1'b1}}));

        // R5
        one_cold_chk: assert property (@(posedge clk) disable iff (rst)
            !inhibit |-> ($countones(sel_out) == LINES - 1));
    end else begin : g_high
        assign sel_out = gated;

        // R6
        inhibit_idle_chk: assert property (@(posedge clk) disable iff (rst)
            inhibit |-> (sel_out == '0));

        // R4
        one_hot_chk: assert property (@(posedge clk) disable iff (rst)
            !inhibit |-> ($countones(sel_out) == 1));
    end

endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
    parameter int unsigned ADDR_W     = lld_pkg::ADDR_W_DEF,
    parameter bit          ACTIVE_LOW = 1'b0,
    localparam int unsigned LINES     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              inhibit,
    output logic [LINES-1:0]  sel_out
);

    logic [ADDR_W-1:0] code_q;
    logic [LINES-1:0]  onehot;

    lld_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .addr_in (addr_in),
        .code_q  (code_q)
    );

    lld_onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .code   (code_q),
        .onehot (onehot)
    );

    lld_out_drive #(.LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .onehot  (onehot),
        .sel_out (sel_out)
    );

    // R7
    inhibit_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
        (inhibit && !strobe) |=> $stable(code_q));

endmodule

// File: tb/latched_line_decoder_tb_top.sv
`timescale 1ns/1ps
module latched_line_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [3:0]  addr_in = 4'd0;
    logic        inhibit = 1'b0;
    logic [15:0] out_hi;
    logic [15:0] out_lo;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    latched_line_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b0)) dut_i (
        .clk(clk), .rst(rst), .strobe(strobe), .addr_in(addr_in),
        .inhibit(inhibit), .sel_out(out_hi)
    );

    latched_line_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b1)) dut_lo_i (
        .clk(clk), .rst(rst), .strobe(strobe), .addr_in(addr_in),
        .inhibit(inhibit), .sel_out(out_lo)
    );

    function automatic logic [15:0] expect_hi(input int code, input bit inh);
        logic [15:0] v;
        v = 16'd0;
        if (!inh) v[code] = 1'b1;
        return v;
    endfunction

    task automatic check_both(input int code, input bit inh, input string req);
        logic [15:0] eh;
        logic [15:0] el;
        eh = expect_hi(code, inh);
        el = ~eh;
        checks++;
        if (out_hi !== eh) begin
            failures++;
            $display("FAIL %s active-high: actual=%h expected=%h", req, out_hi, eh);
        end
        checks++;
        if (out_lo !== el) begin
            failures++;
            $display("FAIL %s active-low: actual=%h expected=%h", req, out_lo, el);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #5;
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        edge_step();
        edge_step();
        rst = 1'b0;
        // R8: reset leaves code 0
        edge_step();
        check_both(0, 1'b0, "R8 reset state");

        // R1 R3 R4 R5: sweep all codes, transparent
        strobe = 1'b1;
        for (int n = 0; n < 16; n++) begin
            addr_in = 4'(n);
            edge_step();
            check_both(n, 1'b0, "R1 R3 R4 R5 sweep");
        end

        // R2: hold across strobe fall while address moves
        addr_in = 4'd5;
        edge_step();
        strobe = 1'b0;
        for (int k = 0; k < 6; k++) begin
            addr_in = 4'(9 + k);
            edge_step();
            check_both(5, 1'b0, "R2 hold");
        end

        // R6 R7: inhibit during transparent phase
        strobe = 1'b1;
        inhibit = 1'b1;
        addr_in = 4'd7;
        #2;
        check_both(0, 1'b1, "R6 inhibit immediate");
        edge_step();
        check_both(0, 1'b1, "R6 inhibit transparent");
        strobe = 1'b0;
        addr_in = 4'd2;
        edge_step();
        inhibit = 1'b0;
        #2;
        check_both(7, 1'b0, "R7 code loaded under inhibit");

        // R6 R7: inhibit during hold phase
        strobe = 1'b1;
        addr_in = 4'd3;
        edge_step();
        strobe = 1'b0;
        addr_in = 4'd14;
        inhibit = 1'b1;
        for (int k = 0; k < 3; k++) begin
            edge_step();
            check_both(0, 1'b1, "R6 inhibit hold");
        end
        inhibit = 1'b0;
        #2;
        check_both(3, 1'b0, "R7 code held under inhibit");

        // R2 R3: hold of every code in turn
        for (int n = 15; n >= 0; n--) begin
            strobe = 1'b1;
            addr_in = 4'(n);
            edge_step();
            strobe = 1'b0;
            addr_in = ~4'(n);
            edge_step();
            check_both(n, 1'b0, "R2 R3 hold per code");
        end

        // R8: reset clears a nonzero held code
        strobe = 1'b1;
        addr_in = 4'd12;
        edge_step();
        check_both(12, 1'b0, "R1 before reset");
        strobe = 1'b0;
        rst = 1'b1;
        edge_step();
        rst = 1'b0;
        edge_step();
        check_both(0, 1'b0, "R8 reset clears");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule